// File: doc/BRIEF.md
# Keyed Mode Unlock and Register Bank Selector

This block watches host writes to a small port-addressed register space. It holds the module in a standard mode until the control port receives a fixed four-byte key. Once that key is accepted, the block enters an enhanced mode and stays there until reset.

In the enhanced mode, the control port is no longer a key input. It becomes the bank-select register, and the two-bit bank index it drives tells the register file which bank the other port addresses reach. In bank 0 those ports return the live input levels. In bank 1 they return latched event flags. Bank 2 holds the debounce settings.

The key match tolerates idle cycles with the write strobe low. A wrong byte, or a write to any other port, breaks the match. Both outputs are registered, so they change on the clock edge that captures the write.

Top module: `mode_unlock_bank`

## Requirements
- R1: After reset, `enh_mode` is 0 and `bank_sel` is 0.
- R2: Writes to port 7 with the bytes 07h, 0Dh, 06h and 12h, in that order, set `enh_mode` on the edge that captures the 12h write. After only the first three bytes, `enh_mode` is still 0. Cycles with `wr_en` low between key writes do not break the match.
- R3: A port-7 write whose byte does not match the current key step restarts the match. If that byte is 07h, it counts as the first key byte.
- R4: A write to any port other than 7 while the key is partly matched drops the match back to the start.
- R5: On the edge that sets `enh_mode`, `bank_sel` is 0.
- R6: In enhanced mode, a port-7 write loads `bank_sel` from data bits 7:6, where 00 means bank 0, 01 (40h) means bank 1 and 10 (80h) means bank 2. Data bits 5:0 are ignored.
- R7: In enhanced mode, a port-7 write with data bits 7:6 equal to 11 leaves `bank_sel` unchanged.
- R8: Once set, `enh_mode` stays 1 until reset. Writes to ports other than 7 change neither output.
- R9: With `wr_en` low, port and data values have no effect on either output.
- R10: In standard mode, `bank_sel` stays 0 whatever is written to port 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_port | input | 3 | Port address of the write |
| wr_data | input | 8 | Write data byte |
| enh_mode | output | 1 | 1 when the module is in enhanced mode |
| bank_sel | output | 2 | Active register bank index (0, 1 or 2) |

## Verification
Two things can happen on the same port-7 write: a mismatch that aborts the match, and a fresh first-key match. A stray 07h placed at the third step creates this collision. The bench judges it correct only if the three bytes that follow complete the unlock.

The unlocking write is the second such case. It both finishes the key and fixes the starting bank, and its data (12h) must not be read as a bank code. The bench checks for bank 0 and enhanced mode together on that edge, then sweeps all 256 data bytes in both modes.

// File: rtl/mode_unlock_bank.sv
module mode_unlock_bank #(
  parameter int PORT_W = 3,
  parameter int DATA_W = 8,
  parameter int CTRL_PORT = 7,
  parameter logic [DATA_W-1:0] KEY0 = 8'h07,
  parameter logic [DATA_W-1:0] KEY1 = 8'h0D,
  parameter logic [DATA_W-1:0] KEY2 = 8'h06,
  parameter logic [DATA_W-1:0] KEY3 = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enh_mode,
  output logic [1:0]        bank_sel
);
  localparam logic [PORT_W-1:0] CTRL = CTRL_PORT[PORT_W-1:0];

  logic [1:0]        step;
  logic [DATA_W-1:0] want;

  always_comb begin
    case (step)
      2'd0:    want = KEY0;
      2'd1:    want = KEY1;
      2'd2:    want = KEY2;
      default: want = KEY3;
    endcase
  end

  wire       ctrl_wr = wr_en && (wr_port == CTRL);
  wire       othr_wr = wr_en && (wr_port != CTRL);
  wire [1:0] code    = wr_data[DATA_W-1 -: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh_mode <= 1'b0;
      bank_sel <= 2'd0;
      step     <= 2'd0;
    end else if (!enh_mode) begin
      if (othr_wr) begin
        step <= 2'd0;
      end else if (ctrl_wr) begin
        if (wr_data == want) begin
          if (step == 2'd3) begin
            enh_mode <= 1'b1;
            bank_sel <= 2'd0;
            step     <= 2'd0;
          end else begin
            step <= step + 2'd1;
          end
        end else begin
          step <= (wr_data == KEY0) ? 2'd1 : 2'd0;
        end
      end
    end else if (ctrl_wr && code != 2'b11) begin
      bank_sel <= code;
    end
  end
endmodule

module mode_unlock_bank_chk #(
  parameter int PORT_W = 3,
  parameter int DATA_W = 8,
  parameter int CTRL_PORT = 7,
  parameter logic [DATA_W-1:0] KEY3 = 8'h12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [PORT_W-1:0] wr_port,
  input logic [DATA_W-1:0] wr_data,
  input logic              enh_mode,
  input logic [1:0]        bank_sel
);
  localparam logic [PORT_W-1:0] CTRL = CTRL_PORT[PORT_W-1:0];

  a_r2_enter_on_last_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(wr_en && wr_port == CTRL && wr_data == KEY3));

  a_r5_bank_zero_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> bank_sel == 2'd0);

  a_r6_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bank_sel != 2'b11);

  a_r7_reserved_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && wr_en && wr_port == CTRL && wr_data[DATA_W-1 -: 2] == 2'b11) |=> $stable(bank_sel));

  a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> enh_mode);

  a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_sel) && $stable(enh_mode));

  a_r10_std_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> bank_sel == 2'd0);
endmodule

bind mode_unlock_bank mode_unlock_bank_chk #(
  .PORT_W(PORT_W), .DATA_W(DATA_W), .CTRL_PORT(CTRL_PORT), .KEY3(KEY3)
) u_chk (.*);

// File: tb/mode_unlock_bank_tb.sv
module mode_unlock_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_port;
  logic [7:0] wr_data;
  logic       enh_mode;
  logic [1:0] bank_sel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  mode_unlock_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .enh_mode(enh_mode), .bank_sel(bank_sel)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    wr_en = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_port = 3'd0; wr_data = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic key();
    wr(7, 8'h07); wr(7, 8'h0D); wr(7, 8'h06); wr(7, 8'h12);
  endtask

  initial begin
    int exp_bank;
    do_reset();
    chk("R1 mode", enh_mode, 0);
    chk("R1 bank", bank_sel, 0);

    // R2: last-byte sweep
    for (int d = 0; d < 256; d++) begin
      do_reset();
      wr(7, 8'h07); wr(7, 8'h0D); wr(7, 8'h06);
      if (d == 0) chk("R2 three bytes", enh_mode, 0);
      wr(7, d[7:0]);
      chk("R2 last byte", enh_mode, (d == 8'h12) ? 1 : 0);
      if (d == 8'h12) chk("R5 bank on entry", bank_sel, 0);
    end

    // R2: idle gaps allowed
    do_reset();
    wr(7, 8'h07); idle(); wr(7, 8'h0D); idle(); idle(); wr(7, 8'h06); idle(); wr(7, 8'h12);
    chk("R2 with gaps", enh_mode, 1);

    // R3: wrong byte at each step
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] k [4];
        k[0] = 8'h07; k[1] = 8'h0D; k[2] = 8'h06; k[3] = 8'h12;
        if (d[7:0] == k[s]) continue;
        do_reset();
        for (int i = 0; i < s; i++) wr(7, k[i]);
        wr(7, d[7:0]);
        for (int i = 1; i < 4; i++) wr(7, k[i]);
        chk("R3 restart", enh_mode, (d == 8'h07) ? 1 : 0);
      end
    end
    do_reset();
    wr(7, 8'h07); wr(7, 8'h0D); wr(7, 8'h07); wr(7, 8'h0D); wr(7, 8'h06); wr(7, 8'h12);
    chk("R3 stray first byte", enh_mode, 1);

    // R4: other port aborts
    for (int p = 0; p < 7; p++) begin
      do_reset();
      wr(7, 8'h07); wr(7, 8'h0D); wr(p[2:0], 8'h06); wr(7, 8'h06); wr(7, 8'h12);
      chk("R4 abort", enh_mode, 0);
      key();
      chk("R4 recover", enh_mode, 1);
    end

    // R9: strobe low
    do_reset();
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b0; wr_port = 3'd7;
      wr_data = (i == 0) ? 8'h07 : (i == 1) ? 8'h0D : (i == 2) ? 8'h06 : 8'h12;
      @(negedge clk);
    end
    chk("R9 no strobe", enh_mode, 0);

    // R10: bank in standard mode
    do_reset();
    wr(7, 8'h80);
    chk("R10 bank std", bank_sel, 0);
    wr(7, 8'h40);
    chk("R10 bank std", bank_sel, 0);

    // R6 / R7: bank sweep
    do_reset();
    key();
    exp_bank = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int d = 0; d < 256; d++) begin
        int dd;
        dd = (pass == 0) ? d : ((d * 37 + 11) % 256);
        wr(7, dd[7:0]);
        if (dd[7:6] != 2'b11) begin
          exp_bank = dd[7:6];
          chk("R6 bank code", bank_sel, exp_bank);
        end else begin
          chk("R7 reserved code", bank_sel, exp_bank);
        end
      end
    end
    wr(7, 8'h40); wr(7, 8'hC0);
    chk("R7 hold bank1", bank_sel, 1);
    wr(7, 8'h9F);
    chk("R6 low bits ignored", bank_sel, 2);

    // R8: other ports and idle in enhanced mode
    for (int p = 0; p < 7; p++) begin
      wr(p[2:0], 8'h40);
      chk("R8 bank held", bank_sel, 2);
      chk("R8 mode held", enh_mode, 1);
    end
    wr(7, 8'h07);
    chk("R8 key byte is bank code", bank_sel, 0);
    chk("R8 mode held", enh_mode, 1);
    wr_en = 1'b0; wr_port = 3'd7; wr_data = 8'h80;
    @(negedge clk);
    chk("R9 strobe low enh", bank_sel, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule